// File: doc/BRIEF.md
# Multi-Mode ADC Scan Sequencer

This block decides which analog input a 12-input converter samples next. A conversion controller pulses `start` to begin a scan. At that edge the block captures a 4-bit channel select, a 2-bit pattern code, a differential flag, a flag that reserves the top input as a reference pin, and a flag for the free-running conversion clock. Each `next` pulse then moves the sequencer to the following channel code. The `last` output is high while the final code of the pattern is on the bus, and a `next` taken while `last` is high ends the scan.

There are four patterns. Code 00 climbs from input 0. Code 10 climbs from input 6. Code 01 repeats one input eight times. Code 11 converts one input once. Select values outside the 12 inputs are clamped so that every finite scan ends. In differential mode the block steps through input pairs. It also presents the negative-side input of the current pair, so the converter front end can route both sides.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, `valid`, `last` and `is_diff` are 0 and `chan` is 0. This is single-ended input 0 with no scan running.
- R2: `start` captures all configuration inputs. Changes to those inputs during a scan have no effect. A `start` during a running scan restarts it with the new configuration.
- R3: Pattern 00 gives channels 0, 1, … up to the effective select. Selects 12 to 15 are treated as 11. `chan` never exceeds 11.
- R4: Pattern 10 gives 6, 7, … up to the effective select. An effective select of 6 or less gives channel 6 alone.
- R5: When the free-running flag is clear, pattern 01 gives the effective select eight times and pattern 11 gives it once.
- R6: With the reference flag set, any select above 10 becomes 10. Channel 11 never appears in a single-ended scan.
- R7: In differential mode, bit 0 of the effective select is the pair polarity and appears in bit 0 of every code. Codes step by 2. Pattern 00 starts at polarity code 0 or 1, and pattern 10 starts at 6 or 7. A climbing scan ends at the pair of the effective select. `neg_chan` equals `chan` XOR 1 in differential mode and 0 in single-ended mode. `is_diff` reports the captured mode.
- R8: With the free-running flag set, patterns 01 and 11 never raise `last`. They keep presenting the effective select until `halt` or a new `start`.
- R9: `last` is high exactly while the final code of a finite pattern is presented. A `next` at that point drops `valid` on the following cycle. A `next` while idle has no effect.
- R10: `halt` ends a scan on the next cycle. `start` wins over `halt` and `next` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a scan with the present configuration |
| next | input | 1 | Advance to the next code |
| halt | input | 1 | Abort the running scan |
| sel | input | 4 | Channel select |
| mode | input | 2 | Scan pattern code |
| diff | input | 1 | Differential pairs when 1 |
| ref_rsvd | input | 1 | Top input reserved as reference |
| ext_clk | input | 1 | Free-running conversion clock |
| valid | output | 1 | A scan is active and `chan` is meaningful |
| chan | output | 4 | Current channel code |
| last | output | 1 | Current code is the final one |
| is_diff | output | 1 | Captured differential flag |
| neg_chan | output | 4 | Negative-side input of the current pair |

## Verification
The corners that are hardest to reach are the ones where several clamping rules meet. Examples are a reserved select with the reference flag set in a differential upper-half scan, or a free-running repeat pattern that only a halt can end. The stimulus reaches all of them by sweeping every select, pattern, mode and flag combination exhaustively. It inverts every configuration input right after each start, so that a stray dependence shows up as a wrong code. Separate sequences cover restart during a scan, start and halt in the same cycle, and next while idle.

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int CW          = 4,
  parameter int NCH         = 12,
  parameter int REPS        = 8,
  parameter int UPPER_START = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          next,
  input  logic          halt,
  input  logic [CW-1:0] sel,
  input  logic [1:0]    mode,
  input  logic          diff,
  input  logic          ref_rsvd,
  input  logic          ext_clk,
  output logic          valid,
  output logic [CW-1:0] chan,
  output logic          last,
  output logic          is_diff,
  output logic [CW-1:0] neg_chan
);
  localparam logic [CW-1:0] MAXC = CW'(NCH - 1);
  localparam logic [CW-1:0] US   = CW'(UPPER_START);
  localparam int CNTW = (REPS > 1) ? $clog2(REPS) : 1;

  logic [CW-1:0] lim, start_c, end_c;
  logic [CW-1:0] code, end_r;
  logic [CNTW-1:0] cnt;
  logic [1:0] m_r;
  logic act, diff_r, ref_r, ext_r, at_end;

  always_comb begin
    lim = sel;
    if (lim > MAXC) lim = MAXC;
    if (ref_rsvd && lim > MAXC - 1'b1) lim = MAXC - 1'b1;
    start_c = lim;
    end_c   = lim;
    case (mode)
      2'b00: start_c = diff ? {{(CW-1){1'b0}}, lim[0]} : '0;
      2'b10: begin
        if (diff) begin
          start_c = {US[CW-1:1], lim[0]};
          if (lim[CW-1:1] < US[CW-1:1]) end_c = start_c;
        end else begin
          start_c = US;
          if (lim < US) end_c = US;
        end
      end
      default: ;
    endcase
  end

  always_comb begin
    case (m_r)
      2'b01:   at_end = !ext_r && cnt == CNTW'(REPS - 1);
      2'b11:   at_end = !ext_r;
      default: at_end = code == end_r;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act <= 1'b0; code <= '0; end_r <= '0; cnt <= '0;
      m_r <= 2'b11; diff_r <= 1'b0; ref_r <= 1'b0; ext_r <= 1'b0;
    end else if (start) begin
      act <= 1'b1; code <= start_c; end_r <= end_c; cnt <= '0;
      m_r <= mode; diff_r <= diff; ref_r <= ref_rsvd; ext_r <= ext_clk;
    end else if (halt) begin
      act <= 1'b0;
    end else if (next && act) begin
      if (at_end) act <= 1'b0;
      else if (!m_r[0]) code <= code + (diff_r ? CW'(2) : CW'(1));
      else cnt <= cnt + 1'b1;
    end
  end

  assign valid    = act;
  assign chan     = code;
  assign last     = act && at_end;
  assign is_diff  = diff_r;
  assign neg_chan = diff_r ? (code ^ CW'(1)) : '0;

  // R3
  range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> chan <= MAXC);
  // R6
  ref_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid && ref_r && !diff_r |-> chan != MAXC);
  // R9
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> valid);
  // R9
  end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last && next && !start && !halt |=> !valid);
  // R7
  polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid && diff_r && $past(valid) && !$past(start) |-> chan[0] == $past(chan[0]));
  // R10
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> valid);
  // R8
  forever_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid && ext_r && m_r[0] |-> !last);
endmodule

// File: tb/adc_scan_seq_test.sv
module adc_scan_seq_test;
  logic clk = 0, rst_n = 0, start = 0, next = 0, halt = 0;
  logic [3:0] sel = 0;
  logic [1:0] mode = 0;
  logic diff = 0, ref_rsvd = 0, ext_clk = 0;
  logic valid, last, is_diff;
  logic [3:0] chan, neg_chan;

  adc_scan_seq uut (.clk(clk), .rst_n(rst_n), .start(start), .next(next), .halt(halt),
    .sel(sel), .mode(mode), .diff(diff), .ref_rsvd(ref_rsvd), .ext_clk(ext_clk),
    .valid(valid), .chan(chan), .last(last), .is_diff(is_diff), .neg_chan(neg_chan));

  always #5 clk = ~clk;

  int nchk = 0, nerr = 0;
  bit done = 0;
  string tag = "R1";
  int q[$];
  int m_idx = 0;
  bit m_act = 0, m_diff = 0, m_forever = 0;

  task automatic chk(bit ok, string what, int a, int e);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, a, e);
    end
  endtask

  function automatic void build(int s, int m, bit d, bit r);
    int l, p, hi;
    q.delete();
    l = (s > 11) ? 11 : s;
    if (r && l > 10) l = 10;
    p = l % 2;
    if (m == 1) begin
      for (int i = 0; i < 8; i++) q.push_back(l);
    end else if (m == 3) begin
      q.push_back(l);
    end else if (!d) begin
      hi = (m == 2 && l < 6) ? 6 : l;
      for (int c = (m == 2) ? 6 : 0; c <= hi; c++) q.push_back(c);
    end else begin
      hi = (m == 2 && l / 2 < 3) ? 3 : l / 2;
      for (int b = (m == 2) ? 3 : 0; b <= hi; b++) q.push_back(2 * b + p);
    end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) m_act = 0;
    else if (start) begin
      build(sel, mode, diff, ref_rsvd);
      m_act = 1; m_idx = 0; m_diff = diff; m_forever = ext_clk && mode[0];
    end else if (halt) m_act = 0;
    else if (next && m_act && !m_forever) begin
      if (m_idx == q.size() - 1) m_act = 0;
      else m_idx++;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n) begin
        chk(valid == 0 && last == 0, "R1 valid/last", {valid, last}, 0);
        chk(chan == 0 && is_diff == 0, "R1 chan/is_diff", chan, 0);
      end else begin
        bit el;
        int ec, en;
        el = m_act && !m_forever && m_idx == q.size() - 1;
        chk(valid == m_act, "valid", valid, m_act);
        chk(last == el, "last", last, el);
        if (m_act) begin
          ec = q[m_idx];
          en = m_diff ? (ec ^ 1) : 0;
          chk(chan == ec, "chan", chan, ec);
          chk(neg_chan == en, "R7 neg_chan", neg_chan, en);
          chk(is_diff == m_diff, "R7 is_diff", is_diff, m_diff);
        end
      end
    end
  end

  task automatic run(int s, int m, bit d, bit r, bit e);
    @(negedge clk);
    sel = s; mode = m; diff = d; ref_rsvd = r; ext_clk = e; start = 1;
    tag = (m == 0) ? "R3" : (m == 2) ? "R4" : (e ? "R8" : "R5");
    if (d) tag = {tag, " R7"};
    if (r) tag = {tag, " R6"};
    tag = {tag, " R9 R2"};
    @(negedge clk);
    start = 0; sel = ~sel; mode = ~mode; diff = ~diff; ref_rsvd = ~ref_rsvd; ext_clk = ~ext_clk;
    for (int k = 0; k < 40; k++) begin
      if (!m_act) break;
      next = (k % 3 != 2);
      halt = (k == 25);
      @(negedge clk);
    end
    halt = 0;
    next = 1;
    @(negedge clk);
    next = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int s = 0; s < 16; s++)
      for (int m = 0; m < 4; m++)
        for (int f = 0; f < 8; f++)
          run(s, m, f[0], f[1], f[2]);
    tag = "R2 restart";
    @(negedge clk); sel = 9; mode = 0; diff = 0; start = 1;
    @(negedge clk); start = 0; next = 1;
    @(negedge clk); next = 0; sel = 4; mode = 2; diff = 1; start = 1;
    @(negedge clk); start = 0;
    repeat (3) @(negedge clk);
    tag = "R10 halt";
    halt = 1;
    @(negedge clk); halt = 0;
    @(negedge clk);
    tag = "R10 start beats halt";
    sel = 3; mode = 3; diff = 0; ref_rsvd = 0; ext_clk = 1; start = 1; halt = 1; next = 1;
    @(negedge clk); start = 0; halt = 0; next = 0;
    @(negedge clk);
    tag = "R9 idle next";
    halt = 1;
    @(negedge clk); halt = 0; next = 1;
    repeat (3) @(negedge clk);
    next = 0;
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      done = 1;
      nchk++; nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule